// File: doc/BRIEF.md
# Wide Pattern Playback and Spy Buffer

This block is a pair of 96-bit test buffers used to exercise signal-processing logic without the real converters. The pattern buffer is loaded by a host, one byte per strobe. Twelve bytes make one word, and each word stands for eight 12-bit converter channels. When the playback side is selected, the words are replayed one per processing tick, so that they emulate converter data. The spy buffer records 96-bit words on the processing side. Its source is either the live converter inputs or the words being replayed from the pattern buffer. The host later drains the spy buffer one byte at a time.

Two setup inputs choose which side owns each buffer. For the pattern buffer, the choice is between the host read port and the processing-side replay. For the spy buffer, the choice is between host writes and processing-side capture. Both sides share one clock. The processing side advances only on cycles where `proc_tick` is high, which models the 40 MHz cadence. Each buffer holds 512 words and behaves as a first-in first-out queue. Its full and empty flags block further writes and reads, and a saturating counter records each rejected word.

Top module: `pattern_spy_buffers`

## Requirements
- R1: After reset both buffers are empty and not full, both overflow counters are 0, and `pat_out_valid` and `host_rd_valid` are 0.
- R2: A host write strobe at `host_addr` = PAT_ADDR (0x1C) stages one byte. Staged byte k (k = 0..11, counted from the first byte after reset or after the last commit) lands in word bits [8k+7:8k]. The word enters the pattern buffer at the clock edge of the twelfth byte and not before. Writes to any address other than PAT_ADDR or SPY_ADDR (0x1B) change neither buffer.
- R3: A buffer holding DEPTH (512) words asserts its full flag. A word offered to a full buffer is dropped, and that buffer's overflow counter rises by exactly 1 (saturating).
- R4: With `cfg_pat_rd_proc` = 1, each cycle with `proc_tick` high and the pattern buffer non-empty pops the oldest word. That word appears on `pat_out`, with `pat_out_valid` = 1, in the cycle after the tick. `pat_out_valid` is 0 in every other cycle.
- R5: A host read strobe at a readable buffer address returns one byte on `host_rdata`, with `host_rd_valid` = 1, in the next cycle. The twelve bytes of the head word come out with bits [7:0] first and bits [95:88] last, and the word is popped after its twelfth byte.
- R6: A host read of an empty buffer yields `host_rd_valid` = 0 and changes nothing.
- R7: While `cfg_pat_rd_proc` = 1, host reads at PAT_ADDR are ignored (`host_rd_valid` = 0, nothing popped). While it is 0, `proc_tick` does not pop the pattern buffer.
- R8: With `cfg_spy_wr_proc` = 1 and `cfg_spy_src_pat` = 0, each cycle with `proc_tick` high writes `adc_in` into the spy buffer. Channel c of the word occupies bits [12c+11:12c].
- R9: With `cfg_spy_wr_proc` = 1 and `cfg_spy_src_pat` = 1, every word shown on `pat_out` with `pat_out_valid` = 1 is written into the spy buffer, in replay order.
- R10: With `cfg_spy_wr_proc` = 0, the spy buffer is filled by host bytes at SPY_ADDR, packed as in R2, and `proc_tick` writes nothing into it. With `cfg_spy_wr_proc` = 1, host writes at SPY_ADDR are ignored.
- R11: When the spy buffer is full, each processing-side capture is dropped and counted in `spy_ovf_cnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by host and processing sides |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pat_rd_proc | input | 1 | 1: pattern buffer read by replay; 0: read by host |
| cfg_spy_wr_proc | input | 1 | 1: spy buffer written by processing side; 0: by host |
| cfg_spy_src_pat | input | 1 | Processing-side spy source: 1 replayed pattern, 0 live inputs |
| host_addr | input | ADDR_W | Host buffer address |
| host_wr | input | 1 | Host byte write strobe |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Host byte read strobe |
| host_rdata | output | 8 | Host read byte |
| host_rd_valid | output | 1 | `host_rdata` holds a byte from the previous read strobe |
| proc_tick | input | 1 | Processing-side cadence enable |
| adc_in | input | N_CHAN*CHAN_W | Live converter channels |
| pat_out | output | N_CHAN*CHAN_W | Replayed pattern word |
| pat_out_valid | output | 1 | `pat_out` carries a fresh word |
| pat_full | output | 1 | Pattern buffer full |
| pat_empty | output | 1 | Pattern buffer empty |
| spy_full | output | 1 | Spy buffer full |
| spy_empty | output | 1 | Spy buffer empty |
| pat_ovf_cnt | output | OVF_W | Words dropped at the pattern buffer |
| spy_ovf_cnt | output | OVF_W | Words dropped at the spy buffer |

## Verification
A staging index that slips by one shows up at the ports within one word. The empty flag then drops a byte early or late, and the replayed word has rotated bytes on the first tick after the commit. A wrong read pointer or byte counter shows up as wrong or reordered bytes on the next read, or as a missing pop that is seen on the thirteenth strobe. A wrong occupancy count is caught only at the boundaries: the full flag after 512 commits, the first dropped word, and the first tick or read after the last word.

// File: rtl/psb_pkg.sv
package psb_pkg;
    // Which side of a buffer the host bus is currently addressing.
    typedef enum logic [1:0] {
        HOST_NONE = 2'd0,
        HOST_PAT  = 2'd1,
        HOST_SPY  = 2'd2
    } host_tgt_e;

    function automatic int bytes_per_word(input int word_w, input int byte_w);
        return word_w / byte_w;
    endfunction
endpackage

// File: rtl/psb_byte_packer.sv
module psb_byte_packer #(
    parameter int WORD_W = 96,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_in,
    output logic              word_commit,
    output logic [WORD_W-1:0] word_out
);
    localparam int NB    = psb_pkg::bytes_per_word(WORD_W, BYTE_W);
    localparam int IDX_W = $clog2(NB);

    typedef struct packed {
        logic [WORD_W-1:0] stage;
        logic [IDX_W-1:0]  idx;
    } pk_state_t;

    pk_state_t         st_d, st_q;
    logic [WORD_W-1:0] merged;

    always_comb begin
        st_d        = st_q;
        merged      = st_q.stage;
        merged[int'(st_q.idx)*BYTE_W +: BYTE_W] = byte_in;
        word_commit = 1'b0;
        if (byte_vld) begin
            st_d.stage = merged;
            if (st_q.idx == IDX_W'(NB - 1)) begin
                word_commit = 1'b1;
                st_d.idx    = '0;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end
    end

    assign word_out = merged;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/psb_byte_reader.sv
module psb_byte_reader #(
    parameter int WORD_W = 96,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic              src_empty,
    input  logic [WORD_W-1:0] head,
    output logic              pop,
    output logic [BYTE_W-1:0] byte_out,
    output logic              byte_vld
);
    localparam int NB    = psb_pkg::bytes_per_word(WORD_W, BYTE_W);
    localparam int IDX_W = $clog2(NB);

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic [BYTE_W-1:0] data;
        logic              vld;
    } rd_state_t;

    rd_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        pop      = 1'b0;
        if (rd_req && !src_empty) begin
            st_d.data = head[int'(st_q.idx)*BYTE_W +: BYTE_W];
            st_d.vld  = 1'b1;
            if (st_q.idx == IDX_W'(NB - 1)) begin
                pop      = 1'b1;
                st_d.idx = '0;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end
    end

    assign byte_out = st_q.data;
    assign byte_vld = st_q.vld;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/psb_fifo.sv
module psb_fifo #(
    parameter int WORD_W = 96,
    parameter int DEPTH  = 512,
    parameter int OVF_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_req,
    output logic [WORD_W-1:0] head,
    output logic              full,
    output logic              empty,
    output logic [OVF_W-1:0]  ovf_cnt
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    typedef struct packed {
        logic [AW-1:0]    wr_ptr;
        logic [AW-1:0]    rd_ptr;
        logic [CW-1:0]    cnt;
        logic [OVF_W-1:0] ovf;
    } ff_state_t;

    ff_state_t         st_d, st_q;
    logic [WORD_W-1:0] mem [DEPTH];
    logic              do_wr, do_rd;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full  = (st_q.cnt == CW'(DEPTH));
    assign empty = (st_q.cnt == '0);
    assign do_wr = wr_req && !full;
    assign do_rd = rd_req && !empty;

    always_comb begin
        st_d = st_q;
        if (do_wr) st_d.wr_ptr = step(st_q.wr_ptr);
        if (do_rd) st_d.rd_ptr = step(st_q.rd_ptr);
        if (do_wr && !do_rd)      st_d.cnt = st_q.cnt + 1'b1;
        else if (do_rd && !do_wr) st_d.cnt = st_q.cnt - 1'b1;
        if (wr_req && full && (st_q.ovf != '1)) st_d.ovf = st_q.ovf + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem[st_q.wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head    = mem[st_q.rd_ptr];
    assign ovf_cnt = st_q.ovf;
endmodule

// File: rtl/pattern_spy_buffers.sv
module pattern_spy_buffers #(
    parameter int                N_CHAN   = 8,
    parameter int                CHAN_W   = 12,
    parameter int                BYTE_W   = 8,
    parameter int                DEPTH    = 512,
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] PAT_ADDR = 8'h1C,
    parameter logic [ADDR_W-1:0] SPY_ADDR = 8'h1B,
    parameter int                OVF_W    = 16,
    localparam int               WORD_W   = N_CHAN * CHAN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_pat_rd_proc,
    input  logic              cfg_spy_wr_proc,
    input  logic              cfg_spy_src_pat,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic [BYTE_W-1:0] host_wdata,
    input  logic              host_rd,
    output logic [BYTE_W-1:0] host_rdata,
    output logic              host_rd_valid,
    input  logic              proc_tick,
    input  logic [WORD_W-1:0] adc_in,
    output logic [WORD_W-1:0] pat_out,
    output logic              pat_out_valid,
    output logic              pat_full,
    output logic              pat_empty,
    output logic              spy_full,
    output logic              spy_empty,
    output logic [OVF_W-1:0]  pat_ovf_cnt,
    output logic [OVF_W-1:0]  spy_ovf_cnt
);
    import psb_pkg::*;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              vld;
    } play_state_t;

    play_state_t       play_d, play_q;
    host_tgt_e         tgt;

    logic              pat_commit, spy_commit;
    logic [WORD_W-1:0] pat_staged, spy_staged;
    logic [WORD_W-1:0] pat_head, spy_head;
    logic              pat_pop_host, spy_pop_host, pat_pop_proc;
    logic [BYTE_W-1:0] pat_byte, spy_byte;
    logic              pat_byte_vld, spy_byte_vld;
    logic              spy_wr_req;
    logic [WORD_W-1:0] spy_wr_word;

    // Host address decode.
    always_comb begin
        if (host_addr == PAT_ADDR)      tgt = HOST_PAT;
        else if (host_addr == SPY_ADDR) tgt = HOST_SPY;
        else                            tgt = HOST_NONE;
    end

    // Byte staging on the write side of each buffer.
    psb_byte_packer #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) pat_pack_i (
        .clk(clk), .rst_n(rst_n),
        .byte_vld(host_wr && (tgt == HOST_PAT)),
        .byte_in(host_wdata),
        .word_commit(pat_commit), .word_out(pat_staged)
    );

    psb_byte_packer #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) spy_pack_i (
        .clk(clk), .rst_n(rst_n),
        .byte_vld(host_wr && (tgt == HOST_SPY) && !cfg_spy_wr_proc),
        .byte_in(host_wdata),
        .word_commit(spy_commit), .word_out(spy_staged)
    );

    // Storage.
    psb_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH), .OVF_W(OVF_W)) pat_fifo_i (
        .clk(clk), .rst_n(rst_n),
        .wr_req(pat_commit), .wr_data(pat_staged),
        .rd_req(pat_pop_host || pat_pop_proc),
        .head(pat_head), .full(pat_full), .empty(pat_empty),
        .ovf_cnt(pat_ovf_cnt)
    );

    psb_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH), .OVF_W(OVF_W)) spy_fifo_i (
        .clk(clk), .rst_n(rst_n),
        .wr_req(spy_wr_req), .wr_data(spy_wr_word),
        .rd_req(spy_pop_host),
        .head(spy_head), .full(spy_full), .empty(spy_empty),
        .ovf_cnt(spy_ovf_cnt)
    );

    // Byte serialisation on the host read side.
    psb_byte_reader #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) pat_rd_i (
        .clk(clk), .rst_n(rst_n),
        .rd_req(host_rd && (tgt == HOST_PAT) && !cfg_pat_rd_proc),
        .src_empty(pat_empty), .head(pat_head),
        .pop(pat_pop_host), .byte_out(pat_byte), .byte_vld(pat_byte_vld)
    );

    psb_byte_reader #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) spy_rd_i (
        .clk(clk), .rst_n(rst_n),
        .rd_req(host_rd && (tgt == HOST_SPY)),
        .src_empty(spy_empty), .head(spy_head),
        .pop(spy_pop_host), .byte_out(spy_byte), .byte_vld(spy_byte_vld)
    );

    // Processing-side replay of the pattern buffer.
    assign pat_pop_proc = proc_tick && cfg_pat_rd_proc && !pat_empty;

    always_comb begin
        play_d     = play_q;
        play_d.vld = pat_pop_proc;
        if (pat_pop_proc) play_d.word = pat_head;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) play_q <= '0;
        else        play_q <= play_d;
    end

    // Spy write source selection.
    always_comb begin
        if (cfg_spy_wr_proc) begin
            spy_wr_req  = cfg_spy_src_pat ? play_q.vld : proc_tick;
            spy_wr_word = cfg_spy_src_pat ? play_q.word : adc_in;
        end else begin
            spy_wr_req  = spy_commit;
            spy_wr_word = spy_staged;
        end
    end

    assign pat_out       = play_q.word;
    assign pat_out_valid = play_q.vld;
    assign host_rdata    = pat_byte_vld ? pat_byte : spy_byte;
    assign host_rd_valid = pat_byte_vld || spy_byte_vld;
endmodule

// File: rtl/psb_checker.sv
module psb_checker #(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] PAT_ADDR = 8'h1C,
    parameter int                OVF_W    = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] host_addr,
    input logic              host_rd,
    input logic              cfg_pat_rd_proc,
    input logic              proc_tick,
    input logic              pat_empty,
    input logic              pat_full,
    input logic              spy_empty,
    input logic              spy_full,
    input logic              pat_out_valid,
    input logic              host_rd_valid,
    input logic [OVF_W-1:0]  pat_ovf_cnt,
    input logic [OVF_W-1:0]  spy_ovf_cnt
);
    // R3: a full pattern buffer cannot also be empty
    p_pat_full_not_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pat_full |-> !pat_empty);

    // R11: same for the spy buffer
    p_spy_full_not_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
        spy_full |-> !spy_empty);

    // R3: overflow counter moves by at most one per cycle
    p_ovf_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (pat_ovf_cnt == $past(pat_ovf_cnt)
                          || pat_ovf_cnt == $past(pat_ovf_cnt) + 1'b1));

    // R11: spy overflow only rises while the spy buffer was full
    p_spy_ovf_when_full_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && spy_ovf_cnt != $past(spy_ovf_cnt)) |-> $past(spy_full));

    // R4: a replayed word follows a qualifying tick
    p_replay_after_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pat_out_valid |-> $past(proc_tick && cfg_pat_rd_proc && !pat_empty));

    // R5: returned byte follows a read strobe
    p_rd_valid_after_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd_valid |-> $past(host_rd));

    // R6: reading an empty pattern buffer returns nothing
    p_empty_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(host_rd && host_addr == PAT_ADDR && !cfg_pat_rd_proc && pat_empty)
        |-> !host_rd_valid);

    // R7: host reads of the pattern buffer are blocked during replay
    p_pat_host_read_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(host_rd && host_addr == PAT_ADDR && cfg_pat_rd_proc) |-> !host_rd_valid);
endmodule

bind pattern_spy_buffers psb_checker #(
    .ADDR_W(ADDR_W), .PAT_ADDR(PAT_ADDR), .OVF_W(OVF_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
    .cfg_pat_rd_proc(cfg_pat_rd_proc), .proc_tick(proc_tick),
    .pat_empty(pat_empty), .pat_full(pat_full),
    .spy_empty(spy_empty), .spy_full(spy_full),
    .pat_out_valid(pat_out_valid), .host_rd_valid(host_rd_valid),
    .pat_ovf_cnt(pat_ovf_cnt), .spy_ovf_cnt(spy_ovf_cnt)
);

// File: tb/pattern_spy_buffers_tb_top.sv
module pattern_spy_buffers_tb_top;
    localparam logic [7:0] PAT_A = 8'h1C;
    localparam logic [7:0] SPY_A = 8'h1B;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_pat_rd_proc = 1'b0, cfg_spy_wr_proc = 1'b0, cfg_spy_src_pat = 1'b0;
    logic [7:0]  host_addr = '0, host_wdata = '0;
    logic        host_wr = 1'b0, host_rd = 1'b0, proc_tick = 1'b0;
    logic [95:0] adc_in = '0;
    logic [7:0]  host_rdata;
    logic        host_rd_valid, pat_out_valid, pat_full, pat_empty, spy_full, spy_empty;
    logic [95:0] pat_out;
    logic [15:0] pat_ovf_cnt, spy_ovf_cnt;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pattern_spy_buffers dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_pat_rd_proc(cfg_pat_rd_proc), .cfg_spy_wr_proc(cfg_spy_wr_proc),
        .cfg_spy_src_pat(cfg_spy_src_pat),
        .host_addr(host_addr), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rd(host_rd), .host_rdata(host_rdata), .host_rd_valid(host_rd_valid),
        .proc_tick(proc_tick), .adc_in(adc_in),
        .pat_out(pat_out), .pat_out_valid(pat_out_valid),
        .pat_full(pat_full), .pat_empty(pat_empty),
        .spy_full(spy_full), .spy_empty(spy_empty),
        .pat_ovf_cnt(pat_ovf_cnt), .spy_ovf_cnt(spy_ovf_cnt)
    );

    task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // All tasks start and end right after a falling edge.
    task automatic wr_byte(input logic [7:0] a, input logic [7:0] b);
        host_addr = a; host_wdata = b; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic wr_word(input logic [7:0] a, input logic [95:0] w);
        for (int k = 0; k < 12; k++) wr_byte(a, w[k*8 +: 8]);
    endtask

    task automatic rd_word(input logic [7:0] a, output logic [95:0] w, output bit ok);
        ok = 1'b1;
        w  = '0;
        for (int k = 0; k < 12; k++) begin
            host_addr = a; host_rd = 1'b1;
            @(negedge clk);
            w[k*8 +: 8] = host_rdata;
            if (!host_rd_valid) ok = 1'b0;
            host_rd = 1'b0;
        end
    endtask

    task automatic tick(output logic [95:0] o, output logic v);
        proc_tick = 1'b1;
        @(negedge clk);
        proc_tick = 1'b0;
        o = pat_out;
        v = pat_out_valid;
    endtask

    function automatic logic [95:0] patw(input int i);
        return {32'(i) * 32'h9E3779B1, 32'(i) + 32'h0001_2345, ~32'(i)};
    endfunction

    task automatic t_reset;
        chk(pat_empty && spy_empty, "R1 empty", {pat_empty, spy_empty}, 2'b11);
        chk(!pat_full && !spy_full, "R1 full", {pat_full, spy_full}, 0);
        chk(pat_ovf_cnt == 0 && spy_ovf_cnt == 0, "R1 ovf", {pat_ovf_cnt, spy_ovf_cnt}, 0);
        chk(!pat_out_valid && !host_rd_valid, "R1 valids", {pat_out_valid, host_rd_valid}, 0);
    endtask

    task automatic t_pack_and_read;
        logic [95:0] w = 96'hFEDC_BA98_7654_3210_0F1E_2D3C;
        logic [95:0] r;
        bit ok;
        wr_word(8'h05, w);  // unmapped address
        chk(pat_empty && spy_empty, "R2 unmapped ignored", {pat_empty, spy_empty}, 2'b11);
        for (int k = 0; k < 11; k++) wr_byte(PAT_A, w[k*8 +: 8]);
        chk(pat_empty, "R2 no commit before 12th byte", pat_empty, 1);
        wr_byte(PAT_A, w[95:88]);
        chk(!pat_empty, "R2 commit on 12th byte", pat_empty, 0);
        // first byte alone shows the LSB first
        host_addr = PAT_A; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        chk(host_rd_valid && host_rdata == w[7:0], "R5 first byte is LSB", host_rdata, w[7:0]);
        for (int k = 1; k < 11; k++) begin
            host_rd = 1'b1;
            @(negedge clk);
            host_rd = 1'b0;
        end
        chk(!pat_empty, "R5 no pop before 12th byte", pat_empty, 0);
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        chk(host_rd_valid && host_rdata == w[95:88], "R5 last byte is MSB", host_rdata, w[95:88]);
        chk(pat_empty, "R5 pop after 12th byte", pat_empty, 1);
        rd_word(PAT_A, r, ok);
        chk(!ok && pat_empty, "R6 read empty gives no data", {ok, pat_empty}, 1);
        // full word round trip
        wr_word(PAT_A, w);
        rd_word(PAT_A, r, ok);
        chk(ok && r == w, "R5 word round trip", r, w);
    endtask

    task automatic t_replay;
        logic [95:0] o, r;
        logic v;
        bit ok;
        for (int i = 0; i < 3; i++) wr_word(PAT_A, patw(100 + i));
        tick(o, v);
        chk(!v, "R7 tick ignored when host reads", v, 0);
        cfg_pat_rd_proc = 1'b1;
        rd_word(PAT_A, r, ok);
        chk(!ok && !pat_empty, "R7 host read blocked during replay", ok, 0);
        for (int i = 0; i < 3; i++) begin
            tick(o, v);
            chk(v && o == patw(100 + i), "R4 replay order", o, patw(100 + i));
            @(negedge clk);
            chk(!pat_out_valid, "R4 valid only after tick", pat_out_valid, 0);
        end
        tick(o, v);
        chk(!v && pat_empty, "R4 tick on empty buffer", v, 0);
        cfg_pat_rd_proc = 1'b0;
    endtask

    task automatic t_spy_live;
        logic [95:0] r, x0, x1;
        bit ok;
        logic [95:0] o;
        logic v;
        cfg_spy_wr_proc = 1'b1; cfg_spy_src_pat = 1'b0;
        wr_word(SPY_A, 96'h1111_2222_3333_4444_5555_6666);
        chk(spy_empty, "R10 host write ignored in capture mode", spy_empty, 1);
        x0 = '0; x1 = '0;
        for (int c = 0; c < 8; c++) begin
            x0[c*12 +: 12] = 12'(c * 12'h111 + 1);
            x1[c*12 +: 12] = 12'(12'hFFF - c);
        end
        adc_in = x0; tick(o, v);
        adc_in = x1; tick(o, v);
        rd_word(SPY_A, r, ok);
        chk(ok && r == x0, "R8 live capture first", r, x0);
        rd_word(SPY_A, r, ok);
        chk(ok && r == x1, "R8 live capture second", r, x1);
        chk(r[11:0] == 12'hFFF && r[95:84] == 12'hFF8, "R8 channel placement", r, x1);
        chk(spy_empty, "R8 spy drained", spy_empty, 1);
    endtask

    task automatic t_spy_pattern;
        logic [95:0] o, r;
        logic v;
        bit ok;
        wr_word(PAT_A, patw(7));
        wr_word(PAT_A, patw(8));
        cfg_pat_rd_proc = 1'b1; cfg_spy_wr_proc = 1'b1; cfg_spy_src_pat = 1'b1;
        adc_in = '1;
        tick(o, v);
        tick(o, v);
        @(negedge clk);
        @(negedge clk);
        rd_word(SPY_A, r, ok);
        chk(ok && r == patw(7), "R9 pattern source first", r, patw(7));
        rd_word(SPY_A, r, ok);
        chk(ok && r == patw(8), "R9 pattern source second", r, patw(8));
        chk(spy_empty, "R9 only replayed words captured", spy_empty, 1);
        cfg_pat_rd_proc = 1'b0; cfg_spy_src_pat = 1'b0;
    endtask

    task automatic t_spy_host;
        logic [95:0] o, r;
        logic v;
        bit ok;
        cfg_spy_wr_proc = 1'b0;
        adc_in = 96'hABC;
        tick(o, v);
        chk(spy_empty, "R10 tick ignored in host-write mode", spy_empty, 1);
        wr_word(SPY_A, 96'h0102_0304_0506_0708_090A_0B0C);
        rd_word(SPY_A, r, ok);
        chk(ok && r == 96'h0102_0304_0506_0708_090A_0B0C, "R10 host-written spy word", r,
            96'h0102_0304_0506_0708_090A_0B0C);
        chk(spy_empty, "R10 spy drained", spy_empty, 1);
    endtask

    task automatic t_pat_full;
        logic [95:0] o;
        logic v;
        int bad = 0;
        for (int i = 0; i < 512; i++) wr_word(PAT_A, patw(i));
        chk(pat_full && pat_ovf_cnt == 0, "R3 full at depth", {pat_full, pat_ovf_cnt}, {1'b1, 16'd0});
        wr_word(PAT_A, 96'hDEAD);
        chk(pat_ovf_cnt == 1 && pat_full, "R3 overflow counted", pat_ovf_cnt, 1);
        cfg_pat_rd_proc = 1'b1;
        for (int i = 0; i < 512; i++) begin
            tick(o, v);
            if (!(v && o == patw(i))) bad++;
        end
        chk(bad == 0, "R3 stored words intact after overflow", bad, 0);
        tick(o, v);
        chk(!v && pat_empty, "R3 dropped word absent", o, 0);
        cfg_pat_rd_proc = 1'b0;
    endtask

    task automatic t_spy_full;
        cfg_spy_wr_proc = 1'b1; cfg_spy_src_pat = 1'b0;
        proc_tick = 1'b1;
        for (int i = 0; i < 514; i++) begin
            adc_in = patw(i);
            @(negedge clk);
        end
        proc_tick = 1'b0;
        chk(spy_full, "R11 spy full", spy_full, 1);
        chk(spy_ovf_cnt == 2, "R11 spy overflow count", spy_ovf_cnt, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pack_and_read();
        t_replay();
        t_spy_live();
        t_spy_pattern();
        t_spy_host();
        t_pat_full();
        t_spy_full();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule